// File: doc/BRIEF.md
# Local bus width and endian converter

This block sits between a host-side word stream and a local bus that may be 32, 16 or 8 bits wide. Each accepted host word carries 32 data bits, four byte enables, a direction and an optional start address. For a write, the word is cut into one, two or four local beats. For a read, the same beats are issued and the data they return is packed back into a 32-bit word. Byte placement on the local lanes is little-endian or big-endian. Both the bus width and the byte order are static configuration inputs.

On narrow buses the four enable outputs change meaning. On a 16-bit bus they carry the low-byte enable, address bit 1 and the high-byte enable. On an 8-bit bus they carry the two low address bits. Words of a burst step through consecutive word addresses unless a new start address is supplied.

The host port is valid/ready. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low while a word is in progress and while its read result is waiting. The read result port is also valid/ready: `rd_valid` and `rd_data` hold until `rd_ready` is seen. On the local side, each beat is offered with `lb_valid`. The beat completes on an edge where `lb_done` is high, and its outputs hold still until then.

Top module: `lb_width_conv`

## Requirements
- R1: `in_ready` is high only when no word is in progress and no read result is pending. A word is taken on an edge with `in_valid` and `in_ready` high. While `lb_valid` is high and `lb_done` is low, `lb_addr`, `lb_en` and `lb_wdata` do not change.
- R2: In 32-bit mode (`cfg_width`=00) with little-endian order (`cfg_big_end`=0), a write is one beat. `lb_wdata` equals the host word and `lb_en[i]` equals host enable i.
- R3: In 32-bit big-endian mode, the bytes are fully reversed: host 12345678h appears as 78563412h. The enables are reversed the same way, so `lb_en[3]` is host enable 0.
- R4: In 16-bit mode (`cfg_width`=01), host bits [15:0] go in the first beat and bits [31:16] in the second. `lb_en[0]` is the enable of the beat's even byte, `lb_en[1]` is address bit 1 (0 then 1), `lb_en[2]` is 0, and `lb_en[3]` is the enable of the odd byte. In little-endian order the odd byte is on lanes [15:8] and the even byte on [7:0]; lanes [31:16] are 0.
- R5: In 16-bit big-endian mode, the even byte of each beat is on lanes [31:24] and the odd byte on [23:16]; lanes [15:0] are 0.
- R6: In 8-bit mode (`cfg_width` bit 1 set), host bytes go out one per beat, byte 0 first. `lb_en[1:0]` is the byte index and `lb_en[3:2]` is 0. The byte is on lanes [7:0] in little-endian order and on [31:24] in big-endian order; the other lanes are 0.
- R7: A write beat whose bytes are all disabled is not issued. A write with all four enables low issues no beat and still completes.
- R8: A read issues every beat of its width, whatever the enables. `rd_valid` rises after the last beat's `lb_done` edge and holds, with `rd_data` stable, until taken with `rd_ready`.
- R9: A word with `in_first` high uses `in_addr` as its word address. Any other word uses the previous word's address plus one (byte address +4). `lb_addr` stays the same across all beats of a word.
- R10: Read beats are placed back into the word using the same lane mapping as writes, so the returned word is in host byte order in every width and endian mode. Unused lanes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_width | input | 2 | Bus width: 00 = 32, 01 = 16, 1x = 8 bits |
| cfg_big_end | input | 1 | 1 = big-endian lane placement |
| in_valid | input | 1 | Host word offered |
| in_ready | output | 1 | Host word can be taken |
| in_write | input | 1 | 1 = write, 0 = read |
| in_first | input | 1 | Load `in_addr` instead of continuing the burst |
| in_addr | input | ADDR_W | Word address (byte address bits above 1) |
| in_data | input | 32 | Host write word |
| in_be | input | 4 | Host byte enables, bit i for byte i |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Read word taken |
| rd_data | output | 32 | Reassembled read word |
| lb_valid | output | 1 | Local beat offered |
| lb_write | output | 1 | Direction of the current beat |
| lb_addr | output | ADDR_W | Word address of the current beat |
| lb_wdata | output | 32 | Write lanes |
| lb_en | output | 4 | Byte enables or low address bits |
| lb_rdata | input | 32 | Read lanes |
| lb_done | input | 1 | Current beat completes on this edge |

## Verification
Writes are driven with full, partial and empty enable masks in each width. Full masks check lane placement. Partial masks show whether all-disabled beats are dropped and whether the per-byte enable bits follow their bytes. An empty mask checks the zero-beat path and its effect on the next address. Reads return data with garbage on the unused lanes, in 32-bit big-endian, 16-bit little-endian and 8-bit big-endian modes. This separates a correct inverse mapping from one that reads the wrong lanes or the wrong beat order. Local stalls and a slow result consumer test the hold rules.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;
  localparam int IDX_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_RESP = 2'd2
  } seq_state_t;

  // lowest set bit of a beat-need vector
  function automatic logic [IDX_W-1:0] first_set(input logic [LANES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/lbc_beat_plan.sv
module lbc_beat_plan
  import lbc_pkg::*;
(
  input  logic [1:0]       width,
  input  logic             write,
  input  logic [LANES-1:0] be,
  output logic [LANES-1:0] need
);
  logic is8, is16;
  assign is8  = width[1];
  assign is16 = (width == 2'b01);

  for (genvar i = 0; i < LANES; i++) begin : g_need
    localparam bit IN32 = (i == 0);
    localparam bit IN16 = (i < 2);
    logic half_on;
    if (i < 2) begin : g_half
      assign half_on = |be[2*i +: 2];
    end else begin : g_nohalf
      assign half_on = 1'b0;
    end
    assign need[i] = is8  ? (!write || be[i]) :
                     is16 ? (IN16 && (!write || half_on)) :
                            (IN32 && (!write || (|be)));
  end
endmodule

// File: rtl/lbc_beat_map.sv
module lbc_beat_map
  import lbc_pkg::*;
(
  input  logic [1:0]       width,
  input  logic             big_end,
  input  logic [IDX_W-1:0] beat,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0] be,
  output logic [DATA_W-1:0] lanes,
  output logic [LANES-1:0] en
);
  logic [IDX_W-1:0] lo_i, hi_i;
  logic [7:0] lo_b, hi_b, one_b;

  assign lo_i  = {beat[0], 1'b0};
  assign hi_i  = {beat[0], 1'b1};
  assign lo_b  = wdata[{lo_i, 3'b000} +: 8];
  assign hi_b  = wdata[{hi_i, 3'b000} +: 8];
  assign one_b = wdata[{beat, 3'b000} +: 8];

  always_comb begin
    lanes = '0;
    en    = '0;
    if (width[1]) begin
      if (big_end) lanes[31:24] = one_b;
      else         lanes[7:0]   = one_b;
      en = {2'b00, beat};
    end else if (width[0]) begin
      if (big_end) lanes[31:16] = {lo_b, hi_b};
      else         lanes[15:0]  = {hi_b, lo_b};
      en = {be[hi_i], 1'b0, beat[0], be[lo_i]};
    end else if (big_end) begin
      for (int k = 0; k < LANES; k++) begin
        lanes[8*(LANES-1-k) +: 8] = wdata[8*k +: 8];
        en[LANES-1-k]             = be[k];
      end
    end else begin
      lanes = wdata;
      en    = be;
    end
  end
endmodule

// File: rtl/lbc_read_pack.sv
module lbc_read_pack
  import lbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [1:0]        width,
  input  logic              big_end,
  input  logic [IDX_W-1:0]  beat,
  input  logic [DATA_W-1:0] lanes,
  output logic [DATA_W-1:0] word
);
  logic [7:0] even_b, odd_b, one_b;
  logic [IDX_W-1:0] lo_i, hi_i;

  assign lo_i   = {beat[0], 1'b0};
  assign hi_i   = {beat[0], 1'b1};
  assign even_b = big_end ? lanes[31:24] : lanes[7:0];
  assign odd_b  = big_end ? lanes[23:16] : lanes[15:8];
  assign one_b  = big_end ? lanes[31:24] : lanes[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (capture) begin
      if (width[1]) begin
        word[{beat, 3'b000} +: 8] <= one_b;
      end else if (width[0]) begin
        word[{lo_i, 3'b000} +: 8] <= even_b;
        word[{hi_i, 3'b000} +: 8] <= odd_b;
      end else if (big_end) begin
        for (int k = 0; k < LANES; k++) word[8*k +: 8] <= lanes[8*(LANES-1-k) +: 8];
      end else begin
        word <= lanes;
      end
    end
  end
endmodule

// File: rtl/lbc_seq.sv
module lbc_seq
  import lbc_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_write,
  input  logic              in_first,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LANES-1:0]  in_be,
  input  logic [LANES-1:0]  need_in,
  output logic              in_ready,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic              lb_valid,
  input  logic              lb_done,
  output logic              wr_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [LANES-1:0]  be_q,
  output logic [IDX_W-1:0]  beat_q,
  output logic              capture
);
  seq_state_t       st;
  logic [LANES-1:0] need_q, later;
  logic             accept;

  assign in_ready = (st == ST_IDLE);
  assign rd_valid = (st == ST_RESP);
  assign lb_valid = (st == ST_BEAT);
  assign accept   = in_valid && in_ready;
  assign later    = need_q & (LANES'(4'b1110) << beat_q);
  assign capture  = lb_valid && lb_done && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      need_q <= '0;
      beat_q <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          wr_q   <= in_write;
          data_q <= in_data;
          be_q   <= in_be;
          addr_q <= in_first ? in_addr : addr_q + 1'b1;
          need_q <= need_in;
          beat_q <= first_set(need_in);
          if (|need_in) st <= ST_BEAT;
        end
        ST_BEAT: if (lb_done) begin
          if (|later) beat_q <= first_set(later);
          else        st     <= wr_q ? ST_IDLE : ST_RESP;
        end
        ST_RESP: if (rd_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !lb_valid && !rd_valid); // R1
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_first |=> addr_q == $past(addr_q) + 1'b1); // R9
  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_first |=> addr_q == $past(in_addr)); // R9
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid); // R8
endmodule

// File: rtl/lb_width_conv.sv
module lb_width_conv
  import lbc_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_big_end,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_write,
  input  logic              in_first,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LANES-1:0]  in_be,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              lb_valid,
  output logic              lb_write,
  output logic [ADDR_W-1:0] lb_addr,
  output logic [DATA_W-1:0] lb_wdata,
  output logic [LANES-1:0]  lb_en,
  input  logic [DATA_W-1:0] lb_rdata,
  input  logic              lb_done
);
  logic [LANES-1:0]  need_in, be_q;
  logic [DATA_W-1:0] data_q;
  logic [IDX_W-1:0]  beat_q;
  logic              capture;

  lbc_beat_plan i_plan (
    .width (cfg_width),
    .write (in_write),
    .be    (in_be),
    .need  (need_in)
  );

  lbc_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_write (in_write),
    .in_first (in_first),
    .in_addr  (in_addr),
    .in_data  (in_data),
    .in_be    (in_be),
    .need_in  (need_in),
    .in_ready (in_ready),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .lb_valid (lb_valid),
    .lb_done  (lb_done),
    .wr_q     (lb_write),
    .addr_q   (lb_addr),
    .data_q   (data_q),
    .be_q     (be_q),
    .beat_q   (beat_q),
    .capture  (capture)
  );

  lbc_beat_map i_map (
    .width   (cfg_width),
    .big_end (cfg_big_end),
    .beat    (beat_q),
    .wdata   (data_q),
    .be      (be_q),
    .lanes   (lb_wdata),
    .en      (lb_en)
  );

  lbc_read_pack i_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .width   (cfg_width),
    .big_end (cfg_big_end),
    .beat    (beat_q),
    .lanes   (lb_rdata),
    .word    (rd_data)
  );

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lb_valid && !lb_done |=> lb_valid && $stable(lb_addr) && $stable(lb_en) && $stable(lb_wdata)); // R1
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> $stable(rd_data)); // R8
  AST_EN16_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
    lb_valid && cfg_width == 2'b01 |-> !lb_en[2]); // R4
  AST_EN8_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    lb_valid && cfg_width[1] |-> lb_en[3:2] == 2'b00); // R6
  AST_WR16_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lb_valid && lb_write && cfg_width == 2'b01 |-> lb_en[0] || lb_en[3]); // R7
endmodule

// File: tb/test_lb_width_conv.sv
module test_lb_width_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_width = 2'b00;
  logic        cfg_big_end = 1'b0;
  logic        in_valid = 1'b0, in_write = 1'b0, in_first = 1'b0;
  logic [25:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic [3:0]  in_be = '0;
  logic        rd_ready = 1'b0;
  logic        in_ready, rd_valid, lb_valid, lb_write;
  logic [31:0] rd_data, lb_wdata;
  logic [25:0] lb_addr;
  logic [3:0]  lb_en;
  logic [31:0] lb_rdata = '0;
  logic        lb_done = 1'b0;

  int n_chk = 0, n_bad = 0;
  int log_n = 0;
  bit stall = 1'b0;
  logic [31:0] log_d[8];
  logic [3:0]  log_e[8];
  logic [25:0] log_a[8];
  logic [31:0] rsp[8];

  always #5 clk = ~clk;

  lb_width_conv i_lb_width_conv (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_big_end(cfg_big_end),
    .in_valid(in_valid), .in_ready(in_ready), .in_write(in_write), .in_first(in_first),
    .in_addr(in_addr), .in_data(in_data), .in_be(in_be),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .lb_valid(lb_valid), .lb_write(lb_write), .lb_addr(lb_addr), .lb_wdata(lb_wdata),
    .lb_en(lb_en), .lb_rdata(lb_rdata), .lb_done(lb_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // local-side device: logs each beat, optionally stalls one cycle
  initial begin
    forever begin
      @(negedge clk);
      lb_done = 1'b0;
      if (lb_valid) begin
        if (log_n < 8) begin
          log_d[log_n] = lb_wdata;
          log_e[log_n] = lb_en;
          log_a[log_n] = lb_addr;
          lb_rdata     = rsp[log_n];
        end
        if (stall) begin
          @(negedge clk);
          check("R1 hold wdata", lb_wdata, log_d[log_n]);
          check("R1 hold en", {28'd0, lb_en}, {28'd0, log_e[log_n]});
        end
        log_n++;
        lb_done = 1'b1;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  task automatic issue(input logic wr, input logic first, input logic [25:0] a,
                       input logic [31:0] d, input logic [3:0] be);
    log_n    = 0;
    in_valid = 1'b1;
    in_write = wr;
    in_first = first;
    in_addr  = a;
    in_data  = d;
    in_be    = be;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (wr) while (!in_ready) @(negedge clk);
    else    while (!rd_valid) @(negedge clk);
  endtask

  task automatic take_read(input string req, input logic [31:0] exp, input int hold);
    check(req, rd_data, exp);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R8 result held", {30'd0, rd_valid, in_ready}, 32'd2);
      check("R8 data held", rd_data, exp);
    end
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    check("R1 ready after result", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_reset();
    check("R1 reset outputs", {29'd0, in_ready, lb_valid, rd_valid}, 32'd4);
  endtask

  task automatic t_w32le();
    cfg_width = 2'b00; cfg_big_end = 1'b0; stall = 1'b1;
    issue(1'b1, 1'b1, 26'h100, 32'h12345678, 4'b1111);
    stall = 1'b0;
    check("R2 beat count", log_n, 1);
    check("R2 lanes", log_d[0], 32'h12345678);
    check("R2 en", {28'd0, log_e[0]}, 32'hF);
    check("R9 start addr", {6'd0, log_a[0]}, 32'h100);
  endtask

  task automatic t_w32be();
    cfg_big_end = 1'b1;
    issue(1'b1, 1'b0, 26'h3FF, 32'h12345678, 4'b0011);
    check("R3 lanes", log_d[0], 32'h78563412);
    check("R3 en reversed", {28'd0, log_e[0]}, 32'hC);
    check("R9 next addr", {6'd0, log_a[0]}, 32'h101);
  endtask

  task automatic t_w16le();
    cfg_width = 2'b01; cfg_big_end = 1'b0; stall = 1'b1;
    issue(1'b1, 1'b1, 26'h200, 32'hAABBCCDD, 4'b1111);
    stall = 1'b0;
    check("R4 beat count", log_n, 2);
    check("R4 beat0 lanes", log_d[0], 32'h0000CCDD);
    check("R4 beat0 en", {28'd0, log_e[0]}, 32'h9);
    check("R4 beat1 lanes", log_d[1], 32'h0000AABB);
    check("R4 beat1 en", {28'd0, log_e[1]}, 32'hB);
    check("R9 addr held", {6'd0, log_a[1]}, 32'h200);
  endtask

  task automatic t_w16be_skip();
    cfg_big_end = 1'b1;
    issue(1'b1, 1'b0, 26'h0, 32'h12345678, 4'b0100);
    check("R7 skipped half", log_n, 1);
    check("R5 lanes", log_d[0], 32'h34120000);
    check("R5 en", {28'd0, log_e[0]}, 32'h3);
  endtask

  // zero-beat write, then an 8-bit write continuing the burst
  task automatic t_empty_then_w8();
    issue(1'b1, 1'b0, 26'h0, 32'hFFFFFFFF, 4'b0000);
    check("R7 empty write beats", log_n, 0);
    cfg_width = 2'b10; cfg_big_end = 1'b0;
    issue(1'b1, 1'b0, 26'h0, 32'h44332211, 4'b1010);
    check("R7 8-bit beats", log_n, 2);
    check("R6 byte1 lanes", log_d[0], 32'h00000022);
    check("R6 byte1 en", {28'd0, log_e[0]}, 32'h1);
    check("R6 byte3 lanes", log_d[1], 32'h00000044);
    check("R6 byte3 en", {28'd0, log_e[1]}, 32'h3);
    check("R9 addr after empty", {6'd0, log_a[0]}, 32'h203);
  endtask

  task automatic t_r8be();
    cfg_width = 2'b11; cfg_big_end = 1'b1;
    rsp[0] = 32'h11ABCDEF; rsp[1] = 32'h22ABCDEF;
    rsp[2] = 32'h33ABCDEF; rsp[3] = 32'h44ABCDEF;
    issue(1'b0, 1'b1, 26'h40, 32'h0, 4'b0000);
    check("R8 read beats", log_n, 4);
    check("R6 read idx2 en", {28'd0, log_e[2]}, 32'h2);
    take_read("R10 8-bit big", 32'h44332211, 0);
  endtask

  task automatic t_r32be();
    cfg_width = 2'b00; cfg_big_end = 1'b1; stall = 1'b1;
    rsp[0] = 32'h78563412;
    issue(1'b0, 1'b1, 26'h80, 32'h0, 4'b1111);
    stall = 1'b0;
    take_read("R10 32-bit big", 32'h12345678, 2);
  endtask

  task automatic t_r16le();
    cfg_width = 2'b01; cfg_big_end = 1'b0;
    rsp[0] = 32'hEEEE2211; rsp[1] = 32'h99994433;
    issue(1'b0, 1'b0, 26'h0, 32'h0, 4'b0001);
    check("R8 16-bit read beats", log_n, 2);
    check("R4 read beat1 en", {28'd0, log_e[1]}, 32'h2);
    check("R9 read addr", {6'd0, log_a[0]}, 32'h81);
    take_read("R10 16-bit little", 32'h44332211, 1);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) rsp[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_w32le();
    t_w32be();
    t_w16le();
    t_w16be_skip();
    t_empty_then_w8();
    t_r8be();
    t_r32be();
    t_r16le();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule